// File: doc/BRIEF.md
# Memory Attribute Remap Unit

This unit sits on the output of address translation. For every access it rewrites the memory region type and the shareability before the access reaches the memory system. It holds one 32-bit remap register for each of three access classes: data, instruction and DMA. Each register holds a replacement code for every inner region type, a replacement code for every outer region type, and a replacement for each of the two values of the Shared bit. The path from the access inputs to the remapped outputs is combinational.

When translation is turned off, the unit makes up a default region type from the access class and the instruction-cache enable. That default then goes through the same remap. As a result, software can choose attributes for untranslated accesses that the enable bits alone cannot give.

The registers are read and written through a system-register port. The port selects a register with a 3-bit code and carries a privilege flag. The unit raises an undefined-instruction flag for any access made without privilege.

Top module: `mem_attr_remap`

## Requirements
- R1: Select code 0 addresses the data register, 1 the instruction register and 2 the DMA register. Any other code, including 4, is left to another block: a write to it changes nothing here and a read returns zero.
- R2: A port access with `cfg_priv` low raises `cfg_undef` in that cycle, changes no register, and returns zero read data. A privileged access never raises `cfg_undef`.
- R3: Inner codes are 3 bits. Each defined code is replaced by its own register field: 000 noncachable by [2:0], 001 strongly ordered by [5:3], 011 device by [8:6], 110 write-through by [11:9], 111 write-back by [14:12].
- R4: Outer codes are 2 bits: 00 noncachable, 01 write-back with allocate, 10 write-through no allocate, 11 write-back no allocate. Code 00 is replaced by field [18:17], 01 by [20:19], 10 by [22:21] and 11 by [24:23].
- R5: Register bits [31:25] are stored as zero and always read as zero, whatever was written to them.
- R6: An incoming Shared bit of 0 is replaced by register bit 15, and an incoming Shared bit of 1 by bit 16.
- R7: With `mmu_on` low, the page-table inputs are ignored. Data and DMA accesses default to inner 001 with outer 00. Instruction accesses default to inner 110 with outer 10 when `icache_on` is high, and to inner 001 with outer 00 when it is low. The incoming Shared bit is taken as 0. The default is then remapped as in R3, R4 and R6.
- R8: An inner code of 010, 100 or 101 comes out unchanged.
- R9: A privileged write changes the remap result from the cycle after the write edge. In the write cycle itself, the outputs still reflect the old contents.
- R10: The access class picks the register: 0 data, 1 instruction, 2 DMA, and 3 is handled as data.
- R11: On reset every register loads 0x01C97CC8 (inner fields 000/001/011/110/111, outer fields 00/01/10/11, bit 15 = 0, bit 16 = 1). This value makes the remap an identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | System-register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 3 | Register select code |
| cfg_priv | input | 1 | Access made in privileged mode |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid in the strobe cycle |
| cfg_undef | output | 1 | Undefined-instruction exception request |
| acc_class | input | 2 | Access class: 0 data, 1 instruction, 2 DMA |
| mmu_on | input | 1 | Translation enabled |
| icache_on | input | 1 | Instruction cache enabled |
| pt_inner | input | 3 | Inner region type from the page tables |
| pt_outer | input | 2 | Outer region type from the page tables |
| pt_shared | input | 1 | Shared bit from the page tables |
| rm_inner | output | 3 | Remapped inner type |
| rm_outer | output | 2 | Remapped outer type |
| rm_shared | output | 1 | Remapped Shared bit |

## Verification
On every cycle, the assertions check the following:
- unprivileged accesses and accesses to foreign select codes leave all three registers untouched;
- reserved read bits stay zero;
- a privileged write lands in the register on the next edge;
- undefined inner codes pass straight through.

Only the bench scenarios can show the per-field replacement values, the translation-off defaults and their remap, the choice of register by access class, and the one-cycle write-to-effect timing. The bench observes these at the outputs after programming non-identity register patterns.

// File: rtl/mem_attr_remap.sv
module mem_attr_remap #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned USED_W = 25,
  parameter int unsigned SEL_W  = 3,
  parameter logic [31:0] RST_VAL = 32'h01C9_7CC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_priv,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              cfg_undef,
  input  logic [1:0]        acc_class,
  input  logic              mmu_on,
  input  logic              icache_on,
  input  logic [2:0]        pt_inner,
  input  logic [1:0]        pt_outer,
  input  logic              pt_shared,
  output logic [2:0]        rm_inner,
  output logic [1:0]        rm_outer,
  output logic              rm_shared
);

  localparam logic [REG_W-1:0] KEEP = {{(REG_W-USED_W){1'b0}}, {USED_W{1'b1}}};
  localparam logic [2:0] IN_NC = 3'b000, IN_SO = 3'b001, IN_DEV = 3'b011,
                         IN_WT = 3'b110, IN_WB = 3'b111;
  localparam logic [1:0] OUT_NC = 2'b00, OUT_WT = 2'b10;

  logic [REG_W-1:0] rg_d, rg_i, rg_a, rg_sel, rd;
  logic [2:0] eff_inner;
  logic [1:0] eff_outer;
  logic       eff_shared, wr_ok, rd_ok, ins_dflt_wt;

  assign wr_ok = cfg_en & cfg_wr & cfg_priv;
  assign rd_ok = cfg_en & ~cfg_wr & cfg_priv;
  assign cfg_undef = cfg_en & ~cfg_priv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rg_d <= RST_VAL & KEEP;
      rg_i <= RST_VAL & KEEP;
      rg_a <= RST_VAL & KEEP;
    end else if (wr_ok) begin
      case (cfg_sel)
        3'd0: rg_d <= cfg_wdata & KEEP;
        3'd1: rg_i <= cfg_wdata & KEEP;
        3'd2: rg_a <= cfg_wdata & KEEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd = '0;
    if (rd_ok) begin
      case (cfg_sel)
        3'd0: rd = rg_d;
        3'd1: rd = rg_i;
        3'd2: rd = rg_a;
        default: rd = '0;
      endcase
    end
  end
  assign cfg_rdata = rd & KEEP;

  always_comb begin
    case (acc_class)
      2'd1:    rg_sel = rg_i;
      2'd2:    rg_sel = rg_a;
      default: rg_sel = rg_d;
    endcase
  end

  assign ins_dflt_wt = (acc_class == 2'd1) & icache_on;
  assign eff_inner  = mmu_on ? pt_inner : (ins_dflt_wt ? IN_WT : IN_SO);
  assign eff_outer  = mmu_on ? pt_outer : (ins_dflt_wt ? OUT_WT : OUT_NC);
  assign eff_shared = mmu_on & pt_shared;

  always_comb begin
    case (eff_inner)
      IN_NC:   rm_inner = rg_sel[2:0];
      IN_SO:   rm_inner = rg_sel[5:3];
      IN_DEV:  rm_inner = rg_sel[8:6];
      IN_WT:   rm_inner = rg_sel[11:9];
      IN_WB:   rm_inner = rg_sel[14:12];
      default: rm_inner = eff_inner;
    endcase
  end

  always_comb begin
    case (eff_outer)
      2'b00:   rm_outer = rg_sel[18:17];
      2'b01:   rm_outer = rg_sel[20:19];
      2'b10:   rm_outer = rg_sel[22:21];
      default: rm_outer = rg_sel[24:23];
    endcase
  end

  assign rm_shared = eff_shared ? rg_sel[16] : rg_sel[15];

  a_r2_user_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_priv) |=> ($stable(rg_d) && $stable(rg_i) && $stable(rg_a)));

  a_r2_user_noread: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_priv) |-> (cfg_rdata == '0));

  a_r1_foreign_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_wr && cfg_sel > 3'd2) |=> ($stable(rg_d) && $stable(rg_i) && $stable(rg_a)));

  a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-1:USED_W] == '0);

  a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (mmu_on && (pt_inner == 3'b010 || pt_inner == 3'b100 || pt_inner == 3'b101))
      |-> (rm_inner == pt_inner));

  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_wr && cfg_priv && cfg_sel == 3'd0)
      |=> (rg_d[USED_W-1:0] == $past(cfg_wdata[USED_W-1:0])));

endmodule

// File: tb/mem_attr_remap_tb.sv
`timescale 1ns/1ps
module mem_attr_remap_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, cfg_wr = 0, cfg_priv = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic cfg_undef;
  logic [1:0] acc_class = 0;
  logic mmu_on = 0, icache_on = 0;
  logic [2:0] pt_inner = 0;
  logic [1:0] pt_outer = 0;
  logic pt_shared = 0;
  logic [2:0] rm_inner;
  logic [1:0] rm_outer;
  logic rm_shared;
  int total = 0, fails = 0;

  localparam logic [31:0] RST = 32'h01C9_7CC8;

  // {class, mmu, icache, inner, outer, shared, exp_inner, exp_outer, exp_shared}
  localparam logic [15:0] VEC [9] = '{
    {2'd0, 1'b1, 1'b0, 3'b111, 2'b11, 1'b1, 3'b111, 2'b11, 1'b1},
    {2'd0, 1'b1, 1'b0, 3'b000, 2'b00, 1'b0, 3'b000, 2'b00, 1'b0},
    {2'd1, 1'b1, 1'b1, 3'b110, 2'b10, 1'b0, 3'b110, 2'b10, 1'b0},
    {2'd2, 1'b1, 1'b0, 3'b011, 2'b01, 1'b1, 3'b011, 2'b01, 1'b1},
    {2'd0, 1'b1, 1'b0, 3'b010, 2'b01, 1'b0, 3'b010, 2'b01, 1'b0},
    {2'd0, 1'b0, 1'b1, 3'b111, 2'b11, 1'b1, 3'b001, 2'b00, 1'b0},
    {2'd1, 1'b0, 1'b1, 3'b000, 2'b11, 1'b1, 3'b110, 2'b10, 1'b0},
    {2'd1, 1'b0, 1'b0, 3'b111, 2'b01, 1'b1, 3'b001, 2'b00, 1'b0},
    {2'd3, 1'b1, 1'b0, 3'b001, 2'b10, 1'b1, 3'b001, 2'b10, 1'b1}
  };

  mem_attr_remap u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_undef(cfg_undef), .acc_class(acc_class), .mmu_on(mmu_on),
    .icache_on(icache_on), .pt_inner(pt_inner), .pt_outer(pt_outer),
    .pt_shared(pt_shared), .rm_inner(rm_inner), .rm_outer(rm_outer),
    .rm_shared(rm_shared)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] c, input logic m, input logic ic,
                     input logic [2:0] in, input logic [1:0] ou, input logic sh);
    @(negedge clk);
    acc_class = c; mmu_on = m; icache_on = ic;
    pt_inner = in; pt_outer = ou; pt_shared = sh;
    #1;
  endtask

  function automatic logic [31:0] res();
    return {26'd0, rm_inner, rm_outer, rm_shared};
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d, input logic p);
    @(negedge clk);
    cfg_en = 1; cfg_wr = 1; cfg_sel = s; cfg_wdata = d; cfg_priv = p;
    @(negedge clk);
    cfg_en = 0; cfg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic p,
                    output logic [31:0] d, output logic u);
    @(negedge clk);
    cfg_en = 1; cfg_wr = 0; cfg_sel = s; cfg_priv = p;
    #1;
    d = cfg_rdata; u = cfg_undef;
    @(negedge clk);
    cfg_en = 0;
  endtask

  initial begin
    #(4 * 200000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic u;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset values, R2 privileged reads raise no exception
    for (int s = 0; s < 3; s++) begin
      rd(s[2:0], 1'b1, d, u);
      chk("R11 reset value", d, RST);
      chk("R2 priv read no undef", {31'd0, u}, 32'd0);
    end

    // R11 identity, R7 defaults, R8 passthrough, R10 class 3
    for (int k = 0; k < 9; k++) begin
      acc(VEC[k][15:14], VEC[k][13], VEC[k][12], VEC[k][11:9], VEC[k][8:7], VEC[k][6]);
      chk($sformatf("R11/R7/R8/R10 vector %0d", k), res(), {26'd0, VEC[k][5:0]});
    end

    // R3 R4 R6 R5 with a non-identity data pattern
    wr(3'd0, 32'hFE36_90A5, 1'b1);
    rd(3'd0, 1'b1, d, u);
    chk("R5 reserved bits read zero", d, 32'h0036_90A5);
    acc(2'd0, 1, 0, 3'b111, 2'b11, 1); chk("R3 R4 R6 wb/wbn/sh1", res(), {26'd0, 3'b001, 2'b00, 1'b0});
    acc(2'd0, 1, 0, 3'b000, 2'b00, 0); chk("R3 R4 R6 nc/nc/sh0", res(), {26'd0, 3'b101, 2'b11, 1'b1});
    acc(2'd0, 1, 0, 3'b011, 2'b01, 0); chk("R3 R4 dev/wba", res(), {26'd0, 3'b010, 2'b10, 1'b1});
    acc(2'd0, 1, 0, 3'b110, 2'b10, 1); chk("R3 R4 wt/wt", res(), {26'd0, 3'b000, 2'b01, 1'b0});
    acc(2'd0, 1, 0, 3'b001, 2'b00, 0); chk("R3 so", res(), {26'd0, 3'b100, 2'b11, 1'b1});
    acc(2'd0, 0, 1, 3'b111, 2'b11, 1); chk("R7 mmu off data remapped", res(), {26'd0, 3'b100, 2'b11, 1'b1});
    acc(2'd3, 1, 0, 3'b111, 2'b11, 1); chk("R10 class 3 uses data", res(), {26'd0, 3'b001, 2'b00, 1'b0});
    acc(2'd1, 1, 0, 3'b111, 2'b11, 1); chk("R10 instr unaffected", res(), {26'd0, 3'b111, 2'b11, 1'b1});
    acc(2'd0, 1, 0, 3'b100, 2'b11, 1); chk("R8 code 100 passthrough", res(), {26'd0, 3'b100, 2'b00, 1'b0});

    // R9 write timing on the instruction register
    @(negedge clk);
    acc_class = 2'd1; mmu_on = 1; pt_inner = 3'b111; pt_outer = 2'b11; pt_shared = 1;
    cfg_en = 1; cfg_wr = 1; cfg_sel = 3'd1; cfg_wdata = 32'h0; cfg_priv = 1;
    #1;
    chk("R9 old value in write cycle", res(), {26'd0, 3'b111, 2'b11, 1'b1});
    @(negedge clk);
    cfg_en = 0; cfg_wr = 0;
    #1;
    chk("R9 new value next cycle", res(), {26'd0, 3'b000, 2'b00, 1'b0});

    // R10 DMA register
    wr(3'd2, 32'h01FF_FFFF, 1'b1);
    acc(2'd2, 1, 0, 3'b000, 2'b00, 0); chk("R10 dma register", res(), {26'd0, 3'b111, 2'b11, 1'b1});

    // R2 user-mode write ignored, undef raised
    @(negedge clk);
    cfg_en = 1; cfg_wr = 1; cfg_sel = 3'd0; cfg_wdata = 32'h0; cfg_priv = 0;
    #1;
    chk("R2 user write undef", {31'd0, cfg_undef}, 32'd1);
    @(negedge clk);
    cfg_en = 0; cfg_wr = 0;
    rd(3'd0, 1'b1, d, u);
    chk("R2 user write ignored", d, 32'h0036_90A5);
    rd(3'd0, 1'b0, d, u);
    chk("R2 user read data zero", d, 32'd0);
    chk("R2 user read undef", {31'd0, u}, 32'd1);

    // R1 foreign select code
    wr(3'd4, 32'hFFFF_FFFF, 1'b1);
    rd(3'd0, 1'b1, d, u); chk("R1 sel4 write leaves data", d, 32'h0036_90A5);
    rd(3'd1, 1'b1, d, u); chk("R1 sel4 write leaves instr", d, 32'h0);
    rd(3'd2, 1'b1, d, u); chk("R1 sel4 write leaves dma", d, 32'h01FF_FFFF);
    rd(3'd4, 1'b1, d, u);
    chk("R1 sel4 read zero", d, 32'd0);
    chk("R1 sel4 no undef", {31'd0, u}, 32'd0);

    // R11 reset restores identity
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(3'd0, 1'b1, d, u);
    chk("R11 reset restores", d, RST);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule